// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block provides three independent 16-bit down-counters behind a byte-wide register interface with four addresses. Addresses 0, 1 and 2 are the counter data ports for channels 0, 1 and 2. Address 3 is the control port.

A control write does one of three things:
- it copies a channel's running count into that channel's output latch;
- it programs the channel's operating mode;
- it issues a readback command that can target several channels at once.

Software loads a reload value with two byte writes to a data port. It reads back either the latched count, one byte at a time, or a one-shot status byte.

All channels count down on a shared tick-enable input. Each terminal count can raise a one-cycle pulse on a shared interrupt line. A status output shows the output level of one channel (channel 2 by default) on bit 5. In mode 0 that level is a sticky terminal-count flag. In mode 3 it is a square wave derived from half the reload value. Every mode other than 0 reloads and fires periodically.

Top module: `pit3_timer`

## Requirements
- R1: After reset every channel holds reload value 0xFFFF, count 0xFFFF, mode 0 and a cleared output flag. The next latched-count read returns the low byte. irq_o and status_o are 0.
- R2: Addresses 0 to 2 are the data ports of channels 0 to 2, and address 3 is the control port. Control bits [7:6] select the channel, and the value 3 means a readback command.
- R3: A control write with access bits [5:4] = 00 copies the selected channel's count into its output latch and leaves its mode unchanged.
- R4: A control write with a non-zero access field sets the channel mode from bits [3:1]. Reload bytes are written low byte first. Only the high-byte write applies the new value: it restarts the count at the reload value and clears the output flag.
- R5: A reload value of zero is stored as 0xFFFF. A reload value is never zero.
- R6: A readback command arms a one-shot status read for each channel whose select bit is set (bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2). The next data read of that channel returns 0x30 | mode<<1. That read clears the armed flag and does not advance the byte order.
- R7: A readback command also latches the current count of every selected channel.
- R8: Latched-count reads alternate low byte, then high byte. A latch command does not reset this order.
- R9: Each cycle with tick_i high decrements every count. A tick at count 1 reloads instead, so the period is the reload value in ticks.
- R10: In mode 0 the first terminal count after a load pulses irq_o once and sets the sticky output flag. In every other mode each terminal count pulses irq_o. A pulse lasts one cycle and follows a cycle in which tick_i was high.
- R11: status_o bit 5 shows the status channel's level. In mode 0 it is the sticky flag. In mode 3 it is high while count > reload/2. In other modes it is 0. All other bits of status_o are 0.
- R12: Reads of the control port return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable shared by all channels |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| irq_o | output | 1 | Terminal-count interrupt pulse |
| status_o | output | 8 | Status channel output level on bit 5 |

## Verification
The bench uses the default parameters: three channels, with channel 2 driving bit 5 of the status output. This lets one run cover all three control selector codes plus the readback code. It can also show that ticks shared between channels never disturb a channel that has just been reloaded.

Small reload values of 2 to 5 bring terminal count, periodic reload and the mode 3 half-period boundary within a few ticks. A zero reload written to the status channel exercises the substitution to 0xFFFF.

// File: rtl/pit3_pkg.sv
package pit3_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_ONESHOT = 3'd0;
  localparam logic [MODE_W-1:0] MODE_SQUARE  = 3'd3;
  localparam logic [CNT_W-1:0]  CNT_MAX      = '1;
endpackage

// File: rtl/pit3_ctrl_dec.sv
module pit3_ctrl_dec
  import pit3_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              wr_i,
  input  logic [7:1]        wdata_i,
  output logic [NUM_CH-1:0] latch_o,
  output logic [NUM_CH-1:0] mode_we_o,
  output logic [NUM_CH-1:0] arm_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [1:0] sel;
  logic       is_rb;
  logic       acc_latch;

  assign sel       = wdata_i[7:6];
  assign is_rb     = (sel == 2'd3);
  assign acc_latch = (wdata_i[5:4] == 2'b00);
  assign mode_o    = wdata_i[3:1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit          = !is_rb && (sel == 2'(i));
    assign arm_o[i]     = wr_i && is_rb && wdata_i[i+1];
    assign latch_o[i]   = wr_i && ((hit && acc_latch) || (is_rb && wdata_i[i+1]));
    assign mode_we_o[i] = wr_i && hit && !acc_latch;
  end
endmodule

// File: rtl/pit3_channel.sv
module pit3_channel
  import pit3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              latch_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              arm_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              pulse_o,
  output logic              level_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_o
);
  logic [CNT_W-1:0]  count_q, reload_q, olatch_q, new_reload;
  logic [BYTE_W-1:0] lo_q;
  logic [MODE_W-1:0] mode_q;
  logic              wr_hi_q, rd_hi_q, armed_q, flag_q, pulse_q;

  assign load_o     = wr_i && wr_hi_q;
  assign new_reload = ({wdata_i, lo_q} == '0) ? CNT_MAX : {wdata_i, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= CNT_MAX;
      reload_q <= CNT_MAX;
      flag_q   <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (load_o) begin
        reload_q <= new_reload;
        count_q  <= new_reload;
        flag_q   <= 1'b0;
      end else if (tick_i) begin
        if (count_q <= CNT_W'(1)) begin
          count_q <= reload_q;
          if (mode_q != MODE_ONESHOT) begin
            pulse_q <= 1'b1;
          end else if (!flag_q) begin
            pulse_q <= 1'b1;
            flag_q  <= 1'b1;
          end
        end else begin
          count_q <= count_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      wr_hi_q  <= 1'b0;
      rd_hi_q  <= 1'b0;
      armed_q  <= 1'b0;
      olatch_q <= '0;
      mode_q   <= MODE_ONESHOT;
    end else begin
      if (wr_i) begin
        wr_hi_q <= !wr_hi_q;
        if (!wr_hi_q) lo_q <= wdata_i;
      end
      if (mode_we_i) mode_q <= mode_i;
      if (latch_i) olatch_q <= count_q;
      if (arm_i) begin
        armed_q <= 1'b1;
      end else if (rd_i) begin
        if (armed_q) armed_q <= 1'b0;
        else         rd_hi_q <= !rd_hi_q;
      end
    end
  end

  always_comb begin
    if (armed_q)      rdata_o = {2'b00, 2'b11, mode_q, 1'b0};
    else if (rd_hi_q) rdata_o = olatch_q[CNT_W-1:BYTE_W];
    else              rdata_o = olatch_q[BYTE_W-1:0];
  end

  always_comb begin
    case (mode_q)
      MODE_ONESHOT: level_o = flag_q;
      MODE_SQUARE:  level_o = (count_q > (reload_q >> 1));
      default:      level_o = 1'b0;
    endcase
  end

  assign pulse_o  = pulse_q;
  assign count_o  = count_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/pit3_timer.sv
module pit3_timer
  import pit3_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int STATUS_CH  = 2,
  parameter int STATUS_BIT = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic [7:0]  status_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic [NUM_CH-1:0]             latch_w, mode_we_w, arm_w, pulse_w, level_w, load_w;
  logic [NUM_CH-1:0][BYTE_W-1:0] rdata_w;
  logic [NUM_CH-1:0][CNT_W-1:0]  count_w, reload_w;
  logic [MODE_W-1:0]             mode_w;
  logic                          ctrl_wr;

  assign ctrl_wr = wr_i && (addr_i == CTRL_ADDR);

  pit3_ctrl_dec #(.NUM_CH(NUM_CH)) u_dec (
    .wr_i     (ctrl_wr),
    .wdata_i  (wdata_i[7:1]),
    .latch_o  (latch_w),
    .mode_we_o(mode_we_w),
    .arm_o    (arm_w),
    .mode_o   (mode_w)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pit3_channel u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .wr_i     (wr_i && (addr_i == 2'(i))),
      .rd_i     (rd_i && (addr_i == 2'(i))),
      .wdata_i  (wdata_i),
      .latch_i  (latch_w[i]),
      .mode_we_i(mode_we_w[i]),
      .mode_i   (mode_w),
      .arm_i    (arm_w[i]),
      .rdata_o  (rdata_w[i]),
      .pulse_o  (pulse_w[i]),
      .level_o  (level_w[i]),
      .count_o  (count_w[i]),
      .reload_o (reload_w[i]),
      .load_o   (load_w[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == 2'(i)) rdata_o = rdata_w[i];
    end
  end

  assign irq_o = |pulse_w;

  always_comb begin
    status_o             = '0;
    status_o[STATUS_BIT] = level_w[STATUS_CH];
  end
endmodule

// File: rtl/pit3_timer_chk.sv
module pit3_timer_chk
  import pit3_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int STATUS_BIT = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         tick_i,
  input logic                         rd_i,
  input logic [1:0]                   addr_i,
  input logic [7:0]                   rdata_o,
  input logic                         irq_o,
  input logic [7:0]                   status_o,
  input logic [NUM_CH-1:0][CNT_W-1:0] count_a,
  input logic [NUM_CH-1:0][CNT_W-1:0] reload_a,
  input logic [NUM_CH-1:0]            load_a
);
  // R10
  irq_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));

  // R12
  ctrl_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |-> (rdata_o == 8'h00));

  // R11
  status_spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~(8'h01 << STATUS_BIT)) == 8'h00);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R5
    reload_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reload_a[i] != '0);
    // R4
    load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_a[i] |=> (count_a[i] == reload_a[i]));
  end
endmodule

bind pit3_timer pit3_timer_chk #(.NUM_CH(NUM_CH), .STATUS_BIT(STATUS_BIT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .status_o(status_o),
  .count_a (count_w),
  .reload_a(reload_w),
  .load_a  (load_w)
);

// File: tb/tb_pit3_timer.sv
module tb_pit3_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;
  // vector: op[19:18] (0 write, 1 read-compare, 2 tick count), addr[17:16], data[15:8], expect[7:0]
  localparam logic [19:0] VEC [NVEC] = '{
    {2'd0, 2'd3, 8'h30, 8'h00},  // R4 ch0 mode 0
    {2'd0, 2'd0, 8'h05, 8'h00},  // R4 low byte
    {2'd0, 2'd0, 8'h00, 8'h00},  // R4 high byte
    {2'd0, 2'd3, 8'h00, 8'h00},  // R3 latch ch0
    {2'd1, 2'd0, 8'h00, 8'h05},  // R8 low first
    {2'd1, 2'd0, 8'h00, 8'h00},  // R8 high
    {2'd2, 2'd0, 8'h02, 8'h00},  // R9 two ticks
    {2'd0, 2'd3, 8'h00, 8'h00},  // R3
    {2'd1, 2'd0, 8'h00, 8'h03},  // R9 count 3
    {2'd1, 2'd0, 8'h00, 8'h00},
    {2'd0, 2'd3, 8'hC2, 8'h00},  // R6 R7 readback ch0
    {2'd1, 2'd0, 8'h00, 8'h30},  // R6 status mode 0
    {2'd1, 2'd0, 8'h00, 8'h03},  // R7 R6 latched, order kept
    {2'd1, 2'd0, 8'h00, 8'h00},
    {2'd0, 2'd3, 8'h74, 8'h00},  // R2 R4 ch1 mode 2
    {2'd0, 2'd1, 8'hCD, 8'h00},
    {2'd0, 2'd1, 8'hAB, 8'h00},
    {2'd0, 2'd3, 8'h40, 8'h00},  // R3 latch ch1
    {2'd1, 2'd1, 8'h00, 8'hCD},
    {2'd1, 2'd1, 8'h00, 8'hAB},
    {2'd0, 2'd3, 8'hC4, 8'h00},  // R6 readback ch1
    {2'd1, 2'd1, 8'h00, 8'h34},  // R3 R6 mode 2 kept
    {2'd1, 2'd1, 8'h00, 8'hCD},  // R7
    {2'd1, 2'd1, 8'h00, 8'hAB},
    {2'd0, 2'd3, 8'hB0, 8'h00},  // ch2 mode 0
    {2'd0, 2'd2, 8'h00, 8'h00},  // R5 zero reload
    {2'd0, 2'd2, 8'h00, 8'h00},
    {2'd0, 2'd3, 8'h80, 8'h00},
    {2'd1, 2'd2, 8'h00, 8'hFF},  // R5
    {2'd1, 2'd2, 8'h00, 8'hFF},  // R5
    {2'd1, 2'd3, 8'h00, 8'h00}   // R12
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, status_o;
  logic       irq_o;
  int n_chk = 0, n_bad = 0, n_irq = 0, n_wide = 0;
  bit finished = 0;

  pit3_timer dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    #1 check(req, rdata_o, exp);
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
      if (irq_o) n_irq++;
      @(negedge clk_i);
      if (irq_o) n_wide++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 status", status_o, 8'h00);
    rd("R12 ctrl read", 2'd3, 8'h00);
    wr(2'd3, 8'hC8);
    rd("R1 R6 reset mode", 2'd2, 8'h30);
    rd("R1 count low", 2'd2, 8'hFF);
    rd("R1 count high", 2'd2, 8'hFF);

    for (int v = 0; v < NVEC; v++) begin
      case (VEC[v][19:18])
        2'd0: wr(VEC[v][17:16], VEC[v][15:8]);
        2'd1: rd($sformatf("R2 vector %0d", v), VEC[v][17:16], VEC[v][7:0]);
        default: tick(int'(VEC[v][15:8]));
      endcase
    end

    // R10 mode 0 fires once
    wr(2'd3, 8'h30); wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    n_irq = 0; n_wide = 0;
    tick(9);
    check("R10 mode0 pulses", 8'(n_irq), 8'd1);
    // R9 R10 periodic mode 2
    wr(2'd3, 8'h34); wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    n_irq = 0;
    tick(9);
    check("R9 R10 periodic pulses", 8'(n_irq), 8'd3);
    check("R10 one cycle", 8'(n_wide), 8'd0);
    wr(2'd3, 8'h30); wr(2'd0, 8'h00); wr(2'd0, 8'h00);

    // R11 sticky flag on ch2
    wr(2'd3, 8'hB0); wr(2'd2, 8'h02); wr(2'd2, 8'h00);
    check("R11 mode0 before", status_o, 8'h00);
    tick(1);
    check("R11 mode0 count1", status_o, 8'h00);
    tick(1);
    check("R11 mode0 tc", status_o, 8'h20);
    tick(2);
    check("R11 sticky", status_o, 8'h20);
    wr(2'd2, 8'h02);
    check("R4 low byte only", status_o, 8'h20);
    wr(2'd2, 8'h00);
    check("R4 flag cleared", status_o, 8'h00);

    // R11 mode 3 square wave, reload 4
    wr(2'd3, 8'hB6); wr(2'd2, 8'h04); wr(2'd2, 8'h00);
    check("R11 sq count4", status_o, 8'h20);
    tick(1);
    check("R11 sq count3", status_o, 8'h20);
    tick(1);
    check("R11 sq count2", status_o, 8'h00);
    n_irq = 0;
    tick(1);
    check("R11 sq count1", status_o, 8'h00);
    tick(1);
    check("R11 sq reload", status_o, 8'h20);
    check("R10 mode3 pulse", 8'(n_irq), 8'd1);

    finish_run();
  end
endmodule